// File: doc/BRIEF.md
# Streaming Ternary Convolution Accelerator

This block multiplies a ternary polynomial A by a regular polynomial B in the ring of integer polynomials modulo x^N - 1, with coefficients taken modulo 2^CW (2048 by default). It sits between two byte-stream channels of a DMA engine. An inbound valid/ready stream delivers the operands, two coefficient pairs per 32-bit beat. An outbound valid/ready stream returns the product in the same packed layout.

A plain configuration pin selects one of two jobs. The encryption job computes A*B in N cycles. The decryption job treats A as the ternary factor F of a key f = 1 + 3F. It accumulates F*B three times and then adds B once, which takes 4N cycles in all, and yields f*B. Each product coefficient of that job is then folded into a ternary residue by two reducers that work in parallel, one per half of an outbound beat.

Back-pressure rules: the inbound port takes data only while it is loading, and is held not-ready at all other times. The outbound port holds its data and last flag unchanged from the cycle valid rises until ready is seen high at a clock edge.

Top module: `conv_stream_accel`

## Requirements
- R1: An inbound beat carries coefficient index 2p in bits [15:0] and index 2p+1 in bits [31:16] (p = beat number from 0). Each half holds B in bits [10:0] and the A code in bits [12:11] of that half. The A codes are 01 = +1, 11 = -1, and 00 or 10 = 0. The top three bits of each half are ignored.
- R2: While idle, `s_tready` is low. A high `s_tvalid` moves the block to loading on the next edge, and the beat is accepted no earlier than that edge's following cycle.
- R3: Loading continues until a beat with `s_tlast` is accepted. `cfg_dec` is sampled on that same edge (1 = decryption, 0 = encryption), and later changes of `cfg_dec` have no effect on the job.
- R4: In encryption, `m_tvalid` rises exactly N clock edges after the edge that accepted the last inbound beat. Output coefficient j then equals the sum over k of A_k*B_((j-k) mod N), reduced mod 2^CW.
- R5: In decryption, `m_tvalid` rises exactly 4N edges after the last inbound beat is accepted. The raw coefficient is (3*(A*B)_j + B_j) mod 2^CW.
- R6: In decryption, each raw coefficient v is centre-lifted to the signed range [-2^(CW-1), 2^(CW-1)-1]. Its residue mod 3 in {-1,0,1} is then sent as 0, 1 or 2^CW-1.
- R7: Outbound beats use the R1 layout, with both A fields and the top three bits of each half zero. There are ceil(N/2) beats, and `m_tlast` is high only on the beat that holds index N-1.
- R8: When N is odd, the upper half of the final inbound beat has no effect on the result, and the upper half of the final outbound beat is all zero.
- R9: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tlast` stay unchanged on the next cycle.
- R10: After reset, `s_tready`, `m_tvalid` and `m_tlast` are low.
- R11: Coefficient indices at or beyond N in extra inbound beats are dropped. Coefficients not delivered before `s_tlast` are treated as zero, because each job starts from cleared operand stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_dec | input | 1 | Job select, sampled with the last inbound beat: 1 decryption, 0 encryption |
| s_tdata | input | 32 | Inbound packed coefficient pairs |
| s_tvalid | input | 1 | Inbound beat valid |
| s_tlast | input | 1 | Inbound final beat marker |
| s_tready | output | 1 | Inbound ready, high only while loading |
| m_tdata | output | 32 | Outbound packed result pairs |
| m_tvalid | output | 1 | Outbound beat valid |
| m_tlast | output | 1 | Outbound final beat marker |
| m_tready | input | 1 | Outbound ready from the sink |

## Verification
The sink first observes the result N edges after the edge that accepted the final inbound beat in encryption, or 4N edges after it in decryption. The bench counts clock edges from that accepting edge. It requires `m_tvalid` to be low one edge before the due cycle and high in the due cycle, sampling on the falling edge. Inbound acceptance is judged from `s_tready` at the falling edge before each rising edge. Outbound beats are compared in the cycle they are taken, and held beats are compared against the value seen one cycle earlier.

// File: rtl/cnv_pkg.sv
package cnv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CONV_E,
    ST_CONV_D,
    ST_DRAIN
  } seq_t;

  localparam logic [1:0] TC_ZERO = 2'b00;
  localparam logic [1:0] TC_POS  = 2'b01;
  localparam logic [1:0] TC_NEG  = 2'b11;
endpackage

// File: rtl/cnv_mau_ring.sv
module cnv_mau_ring #(
  parameter int N  = 7,
  parameter int CW = 11,
  parameter int IW = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  ld_en,
  input  logic [IW-1:0]         ld_idx,
  input  logic [CW-1:0]         ld_lo,
  input  logic [CW-1:0]         ld_hi,
  input  logic                  step,
  input  logic [1:0]            coef,
  output logic [N-1:0][CW-1:0]  acc
);
  import cnv_pkg::*;

  logic [N-1:0][CW-1:0] b_ring;

  for (genvar j = 0; j < N; j++) begin : g_cell
    logic [CW-1:0] b_q, c_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        b_q <= '0;
        c_q <= '0;
      end else if (clr) begin
        b_q <= '0;
        c_q <= '0;
      end else if (ld_en && ld_idx == IW'(j)) begin
        b_q <= ld_lo;
      end else if (ld_en && (ld_idx + IW'(1)) == IW'(j)) begin
        b_q <= ld_hi;
      end else if (step) begin
        b_q <= b_ring[(j + N - 1) % N];
        if (coef == TC_POS)      c_q <= c_q + b_q;
        else if (coef == TC_NEG) c_q <= c_q - b_q;
      end
    end
    assign b_ring[j] = b_q;
    assign acc[j]    = c_q;
  end

  AST_ACC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(acc)); // R4
endmodule

// File: rtl/cnv_mod3.sv
module cnv_mod3 #(
  parameter int CW = 11
) (
  input  logic [CW-1:0] v,
  output logic [CW-1:0] r
);
  localparam int HALF = 2 ** (CW - 1);
  localparam int LIFT = ((HALF + 2) / 3) * 3;

  int s_val, u_val, m_val;

  always_comb begin
    s_val = v[CW-1] ? int'(v) - 2 * HALF : int'(v);
    u_val = s_val + LIFT;
    m_val = u_val % 3;
    if (m_val == 0)      r = '0;
    else if (m_val == 1) r = CW'(1);
    else                 r = '1;
  end

  always_comb begin
    if (!$isunknown(v))
      AST_MOD3_RANGE: assert (r == '0 || r == CW'(1) || r == '1); // R6
  end
endmodule

// File: rtl/conv_stream_accel.sv
module conv_stream_accel #(
  parameter int N  = 7,
  parameter int CW = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_dec,
  input  logic [31:0] s_tdata,
  input  logic        s_tvalid,
  input  logic        s_tlast,
  output logic        s_tready,
  output logic [31:0] m_tdata,
  output logic        m_tvalid,
  output logic        m_tlast,
  input  logic        m_tready
);
  import cnv_pkg::*;

  localparam int NB = (N + 1) / 2;
  localparam int IW = $clog2(N + 2) + 1;
  localparam int XW = (N > 1) ? $clog2(N) : 1;

  seq_t                 state;
  logic                 is_dec;
  logic [IW-1:0]        bcnt, ocnt;
  logic [XW-1:0]        kcnt;
  logic [1:0]           rnd;
  logic [N-1:0][1:0]    a_mem;
  logic [N-1:0][CW-1:0] acc;
  logic                 in_hs, clr, step;
  logic [1:0]           coef;
  logic [IW-1:0]        ld_idx, i0, i1;
  logic                 hi_ok;
  logic [CW-1:0]        lane_raw [2];
  logic [CW-1:0]        lane_red [2];
  logic [CW-1:0]        lane_out [2];

  assign s_tready = (state == ST_LOAD);
  assign in_hs    = s_tvalid && s_tready;
  assign clr      = (state == ST_IDLE) && s_tvalid;
  assign step     = (state == ST_CONV_E) || (state == ST_CONV_D);
  assign ld_idx   = IW'(bcnt << 1);

  always_comb begin
    if (state == ST_CONV_D && rnd == 2'd3) coef = (kcnt == '0) ? TC_POS : TC_ZERO;
    else                                    coef = a_mem[kcnt];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_mem <= '0;
    end else begin
      for (int j = 0; j < N; j++) begin
        if (clr)                                         a_mem[j] <= TC_ZERO;
        else if (in_hs && ld_idx == IW'(j))              a_mem[j] <= s_tdata[12:11];
        else if (in_hs && (ld_idx + IW'(1)) == IW'(j))   a_mem[j] <= s_tdata[28:27];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      is_dec <= 1'b0;
      bcnt   <= '0;
      ocnt   <= '0;
      kcnt   <= '0;
      rnd    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (s_tvalid) begin
          state <= ST_LOAD;
          bcnt  <= '0;
        end
        ST_LOAD: if (in_hs) begin
          if (bcnt != IW'(NB)) bcnt <= bcnt + IW'(1);
          if (s_tlast) begin
            is_dec <= cfg_dec;
            state  <= cfg_dec ? ST_CONV_D : ST_CONV_E;
            kcnt   <= '0;
            rnd    <= '0;
          end
        end
        ST_CONV_E, ST_CONV_D: begin
          if (kcnt == XW'(N - 1)) begin
            kcnt <= '0;
            if (state == ST_CONV_E || rnd == 2'd3) begin
              state <= ST_DRAIN;
              ocnt  <= '0;
            end else begin
              rnd <= rnd + 2'd1;
            end
          end else begin
            kcnt <= kcnt + XW'(1);
          end
        end
        ST_DRAIN: if (m_tready) begin
          if (ocnt == IW'(NB - 1)) state <= ST_IDLE;
          else                     ocnt  <= ocnt + IW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  cnv_mau_ring #(.N(N), .CW(CW), .IW(IW)) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .ld_en  (in_hs),
    .ld_idx (ld_idx),
    .ld_lo  (s_tdata[10:0]),
    .ld_hi  (s_tdata[26:16]),
    .step   (step),
    .coef   (coef),
    .acc    (acc)
  );

  assign i0    = IW'(ocnt << 1);
  assign i1    = i0 + IW'(1);
  assign hi_ok = (i1 < IW'(N));
  assign lane_raw[0] = acc[XW'(i0)];
  assign lane_raw[1] = hi_ok ? acc[XW'(i1)] : '0;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    cnv_mod3 #(.CW(CW)) u_red (.v(lane_raw[l]), .r(lane_red[l]));
    assign lane_out[l] = is_dec ? lane_red[l] : lane_raw[l];
  end

  assign m_tvalid = (state == ST_DRAIN);
  assign m_tlast  = m_tvalid && (ocnt == IW'(NB - 1));
  assign m_tdata  = {5'b0, hi_ok ? lane_out[1] : {CW{1'b0}}, 5'b0, lane_out[0]};

  int dwell;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dwell <= 0;
    else        dwell <= step ? dwell + 1 : 0;
  end

  AST_ENC_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && $past(state) == ST_CONV_E) |-> dwell == N); // R4
  AST_DEC_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && $past(state) == ST_CONV_D) |-> dwell == 4 * N); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast))); // R9
  AST_A_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (m_tdata[31:27] == 5'b0 && m_tdata[15:11] == 5'b0)); // R7
  AST_NO_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid || step) |-> !s_tready); // R2
  if (N % 2 == 1) begin : g_pad_chk
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      m_tlast |-> m_tdata[31:16] == 16'b0); // R8
  end
endmodule

// File: tb/test_conv_stream_accel.sv
module test_conv_stream_accel;
  localparam int N  = 7;
  localparam int CW = 11;
  localparam int NB = (N + 1) / 2;
  localparam int MASK = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_dec = 1'b0;
  logic [31:0] s_tdata = '0;
  logic        s_tvalid = 1'b0;
  logic        s_tlast = 1'b0;
  logic        s_tready;
  logic [31:0] m_tdata;
  logic        m_tvalid;
  logic        m_tlast;
  logic        m_tready = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] lcg = 32'h1234_5678;
  logic [1:0]  ta [N];
  int          tb [N];

  always #4 clk = ~clk;

  conv_stream_accel #(.N(N), .CW(CW)) i_conv_stream_accel (
    .clk(clk), .rst_n(rst_n), .cfg_dec(cfg_dec),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tready(m_tready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int tval(input logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b11) return -1;
    return 0;
  endfunction

  function automatic int expect_coef(input int j, input bit dec);
    int acc = 0;
    int e, s, r;
    for (int k = 0; k < N; k++) acc += tval(ta[k]) * tb[(j - k + N) % N];
    if (!dec) return acc & MASK;
    e = (3 * acc + tb[j]) & MASK;
    s = (e >= (1 << (CW - 1))) ? e - (1 << CW) : e;
    r = ((s % 3) + 3) % 3;
    return (r == 0) ? 0 : (r == 1) ? 1 : MASK;
  endfunction

  function automatic logic [31:0] rnd32();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  task automatic fill_random(input bit with_odd_code);
    for (int i = 0; i < N; i++) begin
      logic [31:0] v = rnd32();
      ta[i] = v[17:16];
      if (!with_odd_code && ta[i] == 2'b10) ta[i] = 2'b11;
      tb[i] = int'(v[CW-1:0]);
    end
  endtask

  // Sends the operands, then checks the R4/R5 latency at the due edge.
  task automatic send(input bit dec, input int extra);
    int total = NB + extra;
    for (int p = 0; p < total; p++) begin
      logic [15:0] lo, hi;
      lo = (2 * p < N) ? {3'b111, ta[2*p], CW'(tb[2*p])} : {3'b101, 2'b01, 11'h7FF};
      hi = (2 * p + 1 < N) ? {3'b111, ta[2*p+1], CW'(tb[2*p+1])} : {3'b011, 2'b11, 11'h555};
      @(negedge clk);
      s_tdata  = {hi, lo};
      s_tvalid = 1'b1;
      s_tlast  = (p == total - 1);
      cfg_dec  = dec;
      if (p == 0) check("R2 not ready while idle", 32'(s_tready), 32'd0);
      while (!s_tready) @(negedge clk);
    end
    @(posedge clk);
    #1;
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
    cfg_dec  = ~dec; // R3: later changes must not alter the job
    repeat ((dec ? 4 * N : N) - 1) @(posedge clk);
    @(negedge clk);
    check(dec ? "R5 valid low before 4N" : "R4 valid low before N", 32'(m_tvalid), 32'd0);
    @(posedge clk);
    @(negedge clk);
    check(dec ? "R5 valid at 4N" : "R4 valid at N", 32'(m_tvalid), 32'd1);
  endtask

  task automatic receive(input bit dec, input bit stall, input string req);
    int q = 0;
    int cyc = 0;
    logic [31:0] held = '0;
    bit was_held = 1'b0;
    while (q < NB) begin
      if (was_held) begin
        check("R9 valid held", 32'(m_tvalid), 32'd1);
        check("R9 data held", m_tdata, held);
      end
      m_tready = stall ? (cyc % 3 == 2) : 1'b1;
      if (m_tvalid && m_tready) begin
        logic [31:0] expw;
        int lo_e, hi_e;
        lo_e = expect_coef(2 * q, dec);
        hi_e = (2 * q + 1 < N) ? expect_coef(2 * q + 1, dec) : 0;
        expw = {5'b0, CW'(hi_e), 5'b0, CW'(lo_e)};
        check(req, m_tdata, expw);
        check("R7 last flag", 32'(m_tlast), 32'(q == NB - 1));
        if (q == NB - 1 && (N % 2 == 1)) check("R8 pad half zero", 32'(m_tdata[31:16]), 32'd0);
        q++;
        was_held = 1'b0;
      end else begin
        was_held = m_tvalid;
        held = m_tdata;
      end
      @(negedge clk);
      cyc++;
    end
    m_tready = 1'b0;
  endtask

  task automatic t_reset;
    check("R10 s_tready reset", 32'(s_tready), 32'd0);
    check("R10 m_tvalid reset", 32'(m_tvalid), 32'd0);
    check("R10 m_tlast reset", 32'(m_tlast), 32'd0);
  endtask

  task automatic t_enc_random;
    fill_random(1'b0);
    send(1'b0, 0);
    receive(1'b0, 1'b0, "R4 R1 encrypt product");
  endtask

  task automatic t_enc_wrap;
    for (int i = 0; i < N; i++) begin
      ta[i] = (i % 2 == 0) ? 2'b01 : 2'b11;
      tb[i] = MASK - i;
    end
    ta[N-1] = 2'b01;
    send(1'b0, 0);
    receive(1'b0, 1'b0, "R4 encrypt wrap mod 2^CW");
  endtask

  task automatic t_dec_random;
    fill_random(1'b0);
    send(1'b1, 0);
    receive(1'b1, 1'b0, "R5 R6 decrypt residues");
  endtask

  task automatic t_dec_center;
    for (int i = 0; i < N; i++) begin
      ta[i] = 2'b00;
      tb[i] = (i == 0) ? 1023 : (i == 1) ? 1024 : (i == 2) ? 2047 : (i == 3) ? 1025 : i;
    end
    send(1'b1, 0);
    receive(1'b1, 1'b0, "R6 centre lift edges");
  endtask

  task automatic t_backpressure;
    fill_random(1'b0);
    send(1'b0, 0);
    receive(1'b0, 1'b1, "R9 stalled encrypt product");
  endtask

  task automatic t_extra_and_pad;
    fill_random(1'b1); // R1: code 10 counts as zero
    send(1'b0, 2);
    receive(1'b0, 1'b0, "R11 R8 R1 extra beats dropped");
  endtask

  task automatic t_short;
    logic [1:0] sa [N];
    int sb [N];
    fill_random(1'b0);
    // R11: only the first beat is sent; the rest must act as zero
    for (int i = 0; i < N; i++) begin
      sa[i] = ta[i];
      sb[i] = tb[i];
    end
    @(negedge clk);
    s_tdata  = {3'b0, ta[1], CW'(tb[1]), 3'b0, ta[0], CW'(tb[0])};
    s_tvalid = 1'b1;
    s_tlast  = 1'b1;
    cfg_dec  = 1'b0;
    while (!s_tready) @(negedge clk);
    @(posedge clk);
    #1;
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
    for (int i = 2; i < N; i++) begin
      ta[i] = 2'b00;
      tb[i] = 0;
    end
    repeat (N) @(posedge clk);
    @(negedge clk);
    receive(1'b0, 1'b0, "R11 undelivered coefficients zero");
    for (int i = 0; i < N; i++) begin
      ta[i] = sa[i];
      tb[i] = sb[i];
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_enc_random();
    t_enc_wrap();
    t_dec_random();
    t_dec_center();
    t_backpressure();
    t_extra_and_pad();
    t_short();
    t_dec_random();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule